// File: doc/BRIEF.md
# Dual-Key Erase Unlock Controller

This controller stands between a mass-erase engine and two agents that want to trigger it: the CPU and a debugger. A persistent protection word is read in at reset. When that word is all zeros, the part is protected, and an erase-all request from the debug side runs only if the CPU and the debugger have each written the same non-zero key into their own key registers. A CPU-side lock bit, which can only be set, freezes the CPU key register. Once it is set, a debugger cannot try keys by having the CPU load them.

When the keys match, or when the part was not protected at reset, a debug erase request starts a fixed-length erase. The block holds a busy flag for a parameterised number of cycles. It then writes the erased value (all ones) back to the persistent word through `nv_word_o` and raises a done flag together with a reset-required flag. The protection status latched at reset does not change until the next reset, which reloads the persistent word.

Top module: `erase_unlock_ctrl`

## Requirements
- R1: During and straight after reset, both key registers read as zero, the lock is open, busy_o, done_o, refused_o, reset_req_o and keys_match_o are 0, and nv_word_o equals the word on nv_word_i.
- R2: prot_active_o is 1 only when the word loaded at reset is all zeros. Any other value, including all ones, leaves the part unprotected.
- R3: cpu_region_erase_i has no effect: nv_word_o and prot_active_o keep their values after it is pulsed.
- R4: While protected and idle, a dbg_erase_i request with keys_match_o low is refused. refused_o pulses high for exactly one cycle in the cycle after the request, and busy_o stays low.
- R5: keys_match_o is 1 only when the CPU key equals the debug key and that key is non-zero. Two zero keys never match.
- R6: A cpu_lock_we_i pulse sets cpu_locked_o, which then stays set until reset. After that, cpu_key_we_i writes are ignored, which is seen on keys_match_o.
- R7: Debug key writes take effect whatever the level of dbg_access_lock_i.
- R8: An accepted request raises busy_o in the next cycle and holds it for exactly ERASE_CYCLES cycles. erase_req_o follows busy_o.
- R9: Key writes on either port are ignored while busy_o or done_o is high.
- R10: When the erase ends, done_o and reset_req_o rise and stay high until reset, and nv_word_o becomes all ones. prot_active_o does not change until a reset loads the new word.
- R11: When unprotected, an idle dbg_erase_i request starts the erase whatever the keys hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads nv_word_i |
| nv_word_i | input | KEY_W | Persistent protection word as read at reset |
| nv_word_o | output | KEY_W | Protection word value to write back to the persistent store |
| prot_active_o | output | 1 | Protection state latched at reset |
| cpu_region_erase_i | input | 1 | CPU erase attempt on the configuration region (ignored) |
| cpu_key_we_i | input | 1 | CPU key write strobe |
| cpu_key_i | input | KEY_W | CPU key write data |
| cpu_lock_we_i | input | 1 | CPU lock set strobe |
| cpu_locked_o | output | 1 | CPU key register is locked |
| dbg_access_lock_i | input | 1 | Debug access-protection level (no effect on this block) |
| dbg_key_we_i | input | 1 | Debug key write strobe |
| dbg_key_i | input | KEY_W | Debug key write data |
| dbg_erase_i | input | 1 | Debug erase-all request |
| keys_match_o | output | 1 | Both keys non-zero and equal |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | Erase finished |
| refused_o | output | 1 | One-cycle pulse: request refused |
| erase_req_o | output | 1 | Erase command to the flash engine |
| reset_req_o | output | 1 | Pin reset or power cycle needed |

## Verification
The bench builds the block with KEY_W = 16 and ERASE_CYCLES = 5. The short erase lets the exact busy length be counted, and lets the done state and the reset that follows be reached in every vector row. The 16-bit keys make the corner values easy to write out: all zeros, all ones, and keys that differ only in the top bit.

// File: rtl/erase_unlock_ctrl.sv
module erase_unlock_ctrl #(
  parameter int KEY_W        = 32,
  parameter int ERASE_CYCLES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] nv_word_i,
  output logic [KEY_W-1:0] nv_word_o,
  output logic             prot_active_o,
  input  logic             cpu_region_erase_i,
  input  logic             cpu_key_we_i,
  input  logic [KEY_W-1:0] cpu_key_i,
  input  logic             cpu_lock_we_i,
  output logic             cpu_locked_o,
  input  logic             dbg_access_lock_i,
  input  logic             dbg_key_we_i,
  input  logic [KEY_W-1:0] dbg_key_i,
  input  logic             dbg_erase_i,
  output logic             keys_match_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             refused_o,
  output logic             erase_req_o,
  output logic             reset_req_o
);
  localparam int CW = $clog2(ERASE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(ERASE_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_t;

  state_t           st;
  logic [CW-1:0]    cnt;
  logic [KEY_W-1:0] cpu_key_q, dbg_key_q, nv_q;
  logic             locked_q, prot_q, refused_q;
  logic             go;
  logic             unused_inputs;

  assign unused_inputs = ^{cpu_region_erase_i, dbg_access_lock_i};

  assign keys_match_o  = (cpu_key_q != '0) && (cpu_key_q == dbg_key_q);
  assign go            = !prot_q || keys_match_o;
  assign busy_o        = (st == S_BUSY);
  assign done_o        = (st == S_DONE);
  assign erase_req_o   = busy_o;
  assign reset_req_o   = done_o;
  assign refused_o     = refused_q;
  assign cpu_locked_o  = locked_q;
  assign prot_active_o = prot_q;
  assign nv_word_o     = nv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      cpu_key_q <= '0;
      dbg_key_q <= '0;
      locked_q  <= 1'b0;
      refused_q <= 1'b0;
      nv_q      <= nv_word_i;
      prot_q    <= (nv_word_i == '0);
    end else begin
      refused_q <= 1'b0;
      if (cpu_lock_we_i) locked_q <= 1'b1;
      case (st)
        S_IDLE: begin
          if (cpu_key_we_i && !locked_q) cpu_key_q <= cpu_key_i;
          if (dbg_key_we_i) dbg_key_q <= dbg_key_i;
          if (dbg_erase_i) begin
            if (go) begin
              st  <= S_BUSY;
              cnt <= '0;
            end else begin
              refused_q <= 1'b1;
            end
          end
        end
        S_BUSY: begin
          if (cnt == LAST) begin
            st   <= S_DONE;
            nv_q <= '1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end
endmodule

module erase_unlock_ctrl_chk #(
  parameter int KEY_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [KEY_W-1:0] nv_word_o,
  input logic [KEY_W-1:0] cpu_key_q,
  input logic             prot_active_o,
  input logic             cpu_region_erase_i,
  input logic             cpu_locked_o,
  input logic             dbg_erase_i,
  input logic             keys_match_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             refused_o
);
  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
  p_nv_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (nv_word_o == '1));
  p_prot_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(prot_active_o));
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_locked_o |=> cpu_locked_o);
  p_key_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_locked_o |=> $stable(cpu_key_q));
  p_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_erase_i && !busy_o && !done_o && prot_active_o && !keys_match_o)
      |=> (refused_o && !busy_o));
  p_open_go_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_erase_i && !busy_o && !done_o && !prot_active_o) |=> busy_o);
  p_keys_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || done_o) |=> $stable(keys_match_o));
  p_cfg_erase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_region_erase_i && !busy_o && !done_o) |=> $stable(nv_word_o));
endmodule

bind erase_unlock_ctrl erase_unlock_ctrl_chk #(.KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nv_word_o(nv_word_o), .cpu_key_q(cpu_key_q),
  .prot_active_o(prot_active_o), .cpu_region_erase_i(cpu_region_erase_i),
  .cpu_locked_o(cpu_locked_o), .dbg_erase_i(dbg_erase_i),
  .keys_match_o(keys_match_o), .busy_o(busy_o), .done_o(done_o),
  .refused_o(refused_o)
);

// File: tb/erase_unlock_ctrl_bench.sv
module erase_unlock_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 16;
  localparam int EC = 5;
  localparam int NV = 6;
  // fields: [33:18] cpu key, [17:2] debug key, [1] lock before cpu write, [0] erase expected
  localparam logic [33:0] VEC [NV] = '{
    {16'h1234, 16'h1234, 1'b0, 1'b1},
    {16'h1234, 16'h1235, 1'b0, 1'b0},
    {16'h0000, 16'h0000, 1'b0, 1'b0},
    {16'hBEEF, 16'hBEEF, 1'b1, 1'b0},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b1},
    {16'h0001, 16'h8001, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [KW-1:0] nv_word_i = '0, cpu_key_i = '0, dbg_key_i = '0, nv_word_o;
  logic cpu_region_erase_i = 0, cpu_key_we_i = 0, cpu_lock_we_i = 0;
  logic dbg_access_lock_i = 0, dbg_key_we_i = 0, dbg_erase_i = 0;
  logic prot_active_o, cpu_locked_o, keys_match_o, busy_o, done_o;
  logic refused_o, erase_req_o, reset_req_o;
  int n_chk = 0, n_fail = 0;
  logic [KW-1:0] saved;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_unlock_ctrl #(.KEY_W(KW), .ERASE_CYCLES(EC)) u_erase_unlock_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [KW-1:0] w);
    rst_n = 0; nv_word_i = w;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic cpu_wr(input logic [KW-1:0] k);
    cpu_key_we_i = 1; cpu_key_i = k; @(negedge clk); cpu_key_we_i = 0;
  endtask

  task automatic dbg_wr(input logic [KW-1:0] k);
    dbg_key_we_i = 1; dbg_key_i = k; @(negedge clk); dbg_key_we_i = 0;
  endtask

  task automatic lock_pulse();
    cpu_lock_we_i = 1; @(negedge clk); cpu_lock_we_i = 0;
  endtask

  task automatic request();
    dbg_erase_i = 1; @(negedge clk); dbg_erase_i = 0;
  endtask

  task automatic count_busy(input string req);
    int n = 0;
    while (busy_o && n < 100) begin
      check({req, " erase_req"}, erase_req_o, 1);
      n++; @(negedge clk);
    end
    check({req, " busy length"}, n, EC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset values
    do_reset('0);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 refused", refused_o, 0);
    check("R1 locked", cpu_locked_o, 0);
    check("R1 match", keys_match_o, 0);
    check("R1 reset_req", reset_req_o, 0);
    check("R1 nv_word", nv_word_o, 0);
    check("R2 protected on zeros", prot_active_o, 1);

    for (int i = 0; i < NV; i++) begin
      do_reset('0);
      if (VEC[i][1]) lock_pulse();
      cpu_wr(VEC[i][33:18]);
      dbg_wr(VEC[i][17:2]);
      request();
      check("R4/R8 busy after request", busy_o, VEC[i][0]);
      check("R4 refused pulse", refused_o, !VEC[i][0]);
      if (VEC[i][0]) begin
        count_busy("R8");
        check("R10 done", done_o, 1);
        check("R10 reset_req", reset_req_o, 1);
        check("R10 nv cleared", nv_word_o, 16'hFFFF);
        check("R10 prot held", prot_active_o, 1);
      end else begin
        @(negedge clk);
        check("R4 refused one cycle", refused_o, 0);
        check("R4 still idle", busy_o, 0);
        check("R5/R6 no match", keys_match_o, 0);
      end
    end

    // R2 other loaded values
    do_reset(16'h00F0);
    check("R2 partial word unprotected", prot_active_o, 0);
    do_reset(16'hFFFF);
    check("R2 erased word unprotected", prot_active_o, 0);
    // R11 unprotected request with empty keys
    request();
    check("R11 erase starts without keys", busy_o, 1);
    count_busy("R11");

    // R3 CPU configuration erase ignored
    do_reset('0);
    cpu_region_erase_i = 1; @(negedge clk); cpu_region_erase_i = 0;
    @(negedge clk);
    check("R3 nv word kept", nv_word_o, 0);
    check("R3 still protected", prot_active_o, 1);

    // R6 lock sticky and gating, R7 debug writes under access lock
    do_reset('0);
    dbg_access_lock_i = 1;
    cpu_wr(16'h5A5A);
    dbg_wr(16'h5A5A);
    check("R7 debug key accepted", keys_match_o, 1);
    lock_pulse();
    check("R6 locked", cpu_locked_o, 1);
    cpu_wr(16'h1111);
    check("R6 cpu write ignored", keys_match_o, 1);
    dbg_wr(16'h1111);
    check("R6 locked key not replaced", keys_match_o, 0);
    repeat (3) @(negedge clk);
    check("R6 lock sticky", cpu_locked_o, 1);
    dbg_access_lock_i = 0;

    // R9 key writes ignored while busy/done
    do_reset('0);
    cpu_wr(16'h0C0C);
    dbg_wr(16'h0C0C);
    request();
    dbg_wr(16'h0D0D);
    cpu_wr(16'h0E0E);
    repeat (EC) @(negedge clk);
    check("R9 done reached", done_o, 1);
    check("R9 keys unchanged", keys_match_o, 1);
    dbg_wr(16'h0000);
    check("R9 write in done ignored", keys_match_o, 1);

    // R10 reset with written-back word unlocks
    saved = nv_word_o;
    do_reset(saved);
    check("R10 unlocked after reset", prot_active_o, 0);
    check("R10 done cleared by reset", done_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule